// File: doc/BRIEF.md
# Timer Output Compare Unit

This block watches a 10-bit timer count that arrives from outside and compares it, every clock, against four compare channels numbered 0 to 3. When the count equals a channel's active compare value, the block pulses that channel's match strobe for one cycle. On channels 0, 1 and 3 it also sets a sticky match flag, and the flag raises an interrupt request when the channel's enable bit is set. Channel 2 has no flag. It is meant to mark the end of a counting period for an external waveform generator, so it only produces a strobe. Every clock cycle counts as one timer tick.

Software reaches the block through a write-only register port. Each channel has a compare register. A control register selects normal or PWM operation and chooses the reload event. There is also an interrupt-enable register and a write-one-to-clear flag register. In normal operation a compare write takes effect at once. In PWM operation writes land in a shadow buffer. The active values of all channels are copied from their buffers together when the chosen top or bottom event arrives, so a period already under way is never cut short or lengthened. Flags also clear when the interrupt controller acknowledges the channel. A force input makes a strobe without a real match.

Top module: `tmr_match_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, all flags, strobes and interrupt requests are 0. All active compare values, buffers, enables and the control bits reset to 0.
- R2: When `cntIn` equals a channel's active compare value at a clock edge, that channel's `matchStrb` bit is 1 for the cycle after that edge. Otherwise it is 0, unless R9 applies.
- R3: A match sets the channel's flag in the cycle after the match, for channels 0, 1 and 3. `flagOut[2]` is always 0.
- R4: `irqReq[i]` is 1 exactly when `flagOut[i]` is 1 and interrupt-enable bit i is 1.
- R5: A flag clears on the edge where `ackIn[i]` is 1, or where software writes address 6 with data bit i set. If a match sets the flag in that same cycle, the flag stays 1.
- R6: With the PWM bit at 0, a write to compare address i becomes the active value of channel i from the next cycle.
- R7: With the PWM bit at 1, compare writes go only to the buffer. The active values do not change until the selected reload event arrives. At that event all four channels take their buffered values on the same edge.
- R8: Control bit 1 picks the reload event: 0 picks `topEvt` and 1 picks `botEvt`. The other event has no effect.
- R9: A 1 on `forceIn[i]` makes `matchStrb[i]` 1 in the next cycle and leaves the flag unchanged.
- R10: Register map for `wrAddr`:
  - addresses 0 to 3 hold the compare values of channels 0 to 3, in bits 9:0;
  - address 4 is control, with bit 0 the PWM mode and bit 1 the reload select;
  - address 5 holds the interrupt enables, bit i for channel i;
  - address 6 is the write-one-to-clear flag register, bit i for channel i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every cycle is a timer tick |
| rstN | input | 1 | Active-low synchronous reset |
| cntIn | input | 10 | Current timer count |
| topEvt | input | 1 | Count has reached its top |
| botEvt | input | 1 | Count has reached its bottom |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 10 | Register write data |
| ackIn | input | 4 | Interrupt acknowledge, one bit per channel |
| forceIn | input | 4 | Force a strobe, one bit per channel |
| matchStrb | output | 4 | One-cycle match strobe per channel |
| flagOut | output | 4 | Sticky match flags (bit 2 always 0) |
| irqReq | output | 4 | Interrupt requests per channel |

## Verification
The bench targets the cycle in which a flag is set and cleared at the same time. A design that let the clear win would lose an interrupt. It also checks that a PWM-mode compare write does not reach the comparator early. An unbuffered design would strobe at the new value in the middle of a period. Each reload select is paired with the opposite event to catch a swapped or ignored select bit. A forced strobe is checked to leave the flags alone, and channel 2 is checked never to raise a flag, since a wrong flag mask would show up there. A long random phase compares strobes, flags and requests with a behavioural model on every cycle.

// File: rtl/tmr_match_pkg.sv
package tmr_match_pkg;
  localparam int CH_COUNT = 4;
  localparam int CNT_BITS = 10;

  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic                reload;   // copy buffers to active, all channels
    logic                direct;   // compare writes go straight to active
    logic [CH_COUNT-1:0] wrSel;    // compare register being written
    logic [CH_COUNT-1:0] clrMask;  // flag clear request
  } ctrlStrb_t;
endpackage

// File: rtl/tmr_match_ctrl.sv
module tmr_match_ctrl
  import tmr_match_pkg::*;
#(
  parameter int NUM_CH = CH_COUNT,
  parameter int ADDR_W = $clog2(NUM_CH + 3)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [NUM_CH-1:0] wrLow,
  input  logic              topEvt,
  input  logic              botEvt,
  input  logic [NUM_CH-1:0] ackIn,
  output ctrlStrb_t         strbs,
  output logic [NUM_CH-1:0] ienQ
);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(NUM_CH);
  localparam logic [ADDR_W-1:0] ADDR_IEN  = ADDR_W'(NUM_CH + 1);
  localparam logic [ADDR_W-1:0] ADDR_CLR  = ADDR_W'(NUM_CH + 2);

  logic pwmModeQ;
  logic reloadAtBotQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwmModeQ     <= 1'b0;
      reloadAtBotQ <= 1'b0;
      ienQ         <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_CTRL) begin
        pwmModeQ     <= wrLow[0];
        reloadAtBotQ <= wrLow[1];
      end
      if (wrAddr == ADDR_IEN) ienQ <= wrLow;
    end
  end

  always_comb begin
    strbs        = '0;
    strbs.direct = !pwmModeQ;
    strbs.reload = pwmModeQ && (reloadAtBotQ ? botEvt : topEvt);
    for (int i = 0; i < NUM_CH; i++) begin
      strbs.wrSel[i] = wrEn && (wrAddr == ADDR_W'(i));
    end
    strbs.clrMask = ackIn | ((wrEn && wrAddr == ADDR_CLR) ? wrLow : '0);
  end

  // R8: the event that is not selected never causes a reload
  p_wrong_event_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pwmModeQ && reloadAtBotQ && !botEvt) |-> !strbs.reload);
  p_wrong_event_top_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pwmModeQ && !reloadAtBotQ && !topEvt) |-> !strbs.reload);
endmodule

// File: rtl/tmr_match_dp.sv
module tmr_match_dp
  import tmr_match_pkg::*;
#(
  parameter int               NUM_CH    = CH_COUNT,
  parameter int               CNT_W     = CNT_BITS,
  parameter logic [NUM_CH-1:0] FLAG_MASK = 4'b1011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cntIn,
  input  logic [CNT_W-1:0]  wrData,
  input  ctrlStrb_t         strbs,
  input  logic [NUM_CH-1:0] forceIn,
  input  logic [NUM_CH-1:0] ienQ,
  output logic [NUM_CH-1:0] matchStrb,
  output logic [NUM_CH-1:0] flagOut,
  output logic [NUM_CH-1:0] irqReq
);
  logic [CNT_W-1:0] bufQ [NUM_CH];
  logic [CNT_W-1:0] actQ [NUM_CH];
  logic [NUM_CH-1:0] hit;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bufQ[i] <= '0;
        actQ[i] <= '0;
      end else begin
        if (strbs.wrSel[i]) bufQ[i] <= wrData;
        if (strbs.reload) actQ[i] <= bufQ[i];
        else if (strbs.wrSel[i] && strbs.direct) actQ[i] <= wrData;
      end
    end

    assign hit[i] = (cntIn == actQ[i]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        matchStrb[i] <= 1'b0;
        flagOut[i]   <= 1'b0;
      end else begin
        matchStrb[i] <= hit[i] | forceIn[i];
        flagOut[i]   <= (flagOut[i] & ~strbs.clrMask[i]) | (hit[i] & FLAG_MASK[i]);
      end
    end

    assign irqReq[i] = flagOut[i] & ienQ[i];

    // R2 and R9: a match or a force shows up as a strobe one cycle later
    p_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
      (hit[i] || forceIn[i]) |=> matchStrb[i]);
    // R3: flag follows a match on flagged channels
    if (FLAG_MASK[i]) begin : g_flag
      p_flag_set_r3: assert property (@(posedge clk) disable iff (!rstN)
        hit[i] |=> flagOut[i]);
    end
    // R5: a flag without a clear request stays set
    p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
      (flagOut[i] && !strbs.clrMask[i]) |=> flagOut[i]);
    p_flag_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
      (strbs.clrMask[i] && !hit[i]) |=> !flagOut[i]);
    // R7: a reload copies the buffer into the active value
    p_reload_r7: assert property (@(posedge clk) disable iff (!rstN)
      strbs.reload |=> (actQ[i] == $past(bufQ[i])));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
      (!strbs.reload && !strbs.direct) |=> $stable(actQ[i]));
  end
endmodule

// File: rtl/tmr_match_unit.sv
module tmr_match_unit
  import tmr_match_pkg::*;
#(
  parameter int                NUM_CH    = CH_COUNT,
  parameter int                CNT_W     = CNT_BITS,
  parameter logic [NUM_CH-1:0] FLAG_MASK = 4'b1011,
  localparam int               ADDR_W    = $clog2(NUM_CH + 3)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cntIn,
  input  logic              topEvt,
  input  logic              botEvt,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [NUM_CH-1:0] ackIn,
  input  logic [NUM_CH-1:0] forceIn,
  output logic [NUM_CH-1:0] matchStrb,
  output logic [NUM_CH-1:0] flagOut,
  output logic [NUM_CH-1:0] irqReq
);
  ctrlStrb_t         strbs;
  logic [NUM_CH-1:0] ienQ;

  tmr_match_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrLow  (wrData[NUM_CH-1:0]),
    .topEvt (topEvt),
    .botEvt (botEvt),
    .ackIn  (ackIn),
    .strbs  (strbs),
    .ienQ   (ienQ)
  );

  tmr_match_dp #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .FLAG_MASK(FLAG_MASK)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .cntIn     (cntIn),
    .wrData    (wrData),
    .strbs     (strbs),
    .forceIn   (forceIn),
    .ienQ      (ienQ),
    .matchStrb (matchStrb),
    .flagOut   (flagOut),
    .irqReq    (irqReq)
  );

  // R4: a request needs a flag behind it
  p_irq_needs_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ((irqReq & ~flagOut) == '0));
endmodule

// File: tb/tmr_match_unit_tb_top.sv
module tmr_match_unit_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] cntIn = 10'd5;
  logic       topEvt = 1'b0, botEvt = 1'b0, wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [9:0] wrData = '0;
  logic [3:0] ackIn = '0, forceIn = '0;
  logic [3:0] matchStrb, flagOut, irqReq;

  int    checks = 0, errors = 0;
  bit    done = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  tmr_match_unit dut_i (
    .clk(clk), .rstN(rstN), .cntIn(cntIn), .topEvt(topEvt), .botEvt(botEvt),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .ackIn(ackIn),
    .forceIn(forceIn), .matchStrb(matchStrb), .flagOut(flagOut), .irqReq(irqReq)
  );

  // behavioural reference model
  int       mAct [4];
  int       mBuf [4];
  bit [3:0] mFlag, mStrb, mIen, mHit, mClr;
  bit       mPwm, mSel, mRel;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin mAct[i] = 0; mBuf[i] = 0; end
      mFlag = 0; mStrb = 0; mIen = 0; mPwm = 0; mSel = 0;
    end else begin
      for (int i = 0; i < 4; i++) mHit[i] = (int'(cntIn) == mAct[i]);
      mClr  = ackIn | ((wrEn && wrAddr == 3'd6) ? wrData[3:0] : 4'd0);
      mFlag = (mFlag & ~mClr) | (mHit & 4'b1011);
      mStrb = mHit | forceIn;
      mRel  = mPwm && (mSel ? botEvt : topEvt);
      if (mRel) for (int i = 0; i < 4; i++) mAct[i] = mBuf[i];
      if (wrEn && wrAddr < 3'd4) begin
        mBuf[wrAddr] = int'(wrData);
        if (!mPwm) mAct[wrAddr] = int'(wrData);
      end
      if (wrEn && wrAddr == 3'd4) begin mPwm = wrData[0]; mSel = wrData[1]; end
      if (wrEn && wrAddr == 3'd5) mIen = wrData[3:0];
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check({curReq, " model strb"}, int'(matchStrb), int'(mStrb));
    check({curReq, " model flag"}, int'(flagOut), int'(mFlag));
    check({curReq, " model irq"}, int'(irqReq), int'(mFlag & mIen));
  endtask

  task automatic wr(logic [2:0] a, logic [9:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R1";
    step();
    check("R1 strb", int'(matchStrb), 0);
    check("R1 flag", int'(flagOut), 0);
    check("R1 irq", int'(irqReq), 0);

    curReq = "R10";
    wr(3'd5, 10'b1011);
    wr(3'd0, 10'd100); wr(3'd1, 10'd200); wr(3'd2, 10'd300); wr(3'd3, 10'd1023);

    curReq = "R2";
    cntIn = 10'd100; step(); cntIn = 10'd5;
    check("R2 strobe ch0", int'(matchStrb), 1);
    check("R3 flag ch0", int'(flagOut), 1);
    check("R4 irq ch0", int'(irqReq), 1);

    curReq = "R6";
    wr(3'd0, 10'd7);
    cntIn = 10'd7; step(); cntIn = 10'd5;
    check("R6 direct write strobe", int'(matchStrb[0]), 1);

    curReq = "R3";
    cntIn = 10'd300; step(); cntIn = 10'd5;
    check("R3 strobe ch2", int'(matchStrb), 4);
    check("R3 no flag ch2", int'(flagOut[2]), 0);

    curReq = "R5";
    wr(3'd6, 10'd1);
    check("R5 w1c clears ch0", int'(flagOut[0]), 0);
    cntIn = 10'd200; step(); cntIn = 10'd5;
    ackIn = 4'b0010; step(); ackIn = 4'b0;
    check("R5 ack clears ch1", int'(flagOut[1]), 0);
    wrEn = 1'b1; wrAddr = 3'd6; wrData = 10'd1; cntIn = 10'd7; step();
    wrEn = 1'b0; cntIn = 10'd5;
    check("R5 set wins over clear", int'(flagOut[0]), 1);
    wr(3'd6, 10'hf);

    curReq = "R4";
    wr(3'd5, 10'b0011);
    cntIn = 10'd1023; step(); cntIn = 10'd5;
    check("R4 flag ch3", int'(flagOut[3]), 1);
    check("R4 irq masked ch3", int'(irqReq[3]), 0);
    wr(3'd6, 10'hf);

    curReq = "R9";
    forceIn = 4'b0010; step(); forceIn = 4'b0;
    check("R9 forced strobe", int'(matchStrb[1]), 1);
    check("R9 no flag", int'(flagOut[1]), 0);

    curReq = "R7";
    wr(3'd4, 10'd1);
    wr(3'd0, 10'd50);
    cntIn = 10'd50; step();
    check("R7 buffered not active", int'(matchStrb[0]), 0);
    cntIn = 10'd7; step();
    check("R7 old value still active", int'(matchStrb[0]), 1);
    topEvt = 1'b1; cntIn = 10'd5; step(); topEvt = 1'b0;
    cntIn = 10'd50; step(); cntIn = 10'd5;
    check("R7 reload at top", int'(matchStrb[0]), 1);

    curReq = "R8";
    wr(3'd4, 10'd3);
    wr(3'd1, 10'd60);
    topEvt = 1'b1; step(); topEvt = 1'b0;
    cntIn = 10'd60; step();
    check("R8 top ignored", int'(matchStrb[1]), 0);
    botEvt = 1'b1; cntIn = 10'd5; step(); botEvt = 1'b0;
    cntIn = 10'd60; step(); cntIn = 10'd5;
    check("R8 reload at bottom", int'(matchStrb[1]), 1);

    curReq = "R7 R5 R2 random";
    for (int n = 0; n < 4000; n++) begin
      cntIn   = 10'($urandom_range(0, 15));
      topEvt  = ($urandom_range(0, 9) == 0);
      botEvt  = ($urandom_range(0, 9) == 0);
      ackIn   = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'd0;
      forceIn = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'd0;
      wrEn    = ($urandom_range(0, 3) == 0);
      wrAddr  = 3'($urandom_range(0, 6));
      wrData  = 10'($urandom_range(0, 15));
      step();
    end
    wrEn = 1'b0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule